// File: doc/BRIEF.md
# Issued-Prefetch Line Filter

This block keeps an approximate record of the cache lines that were recently sent out as prefetches. It sits beside a prefetch queue. Before a candidate prefetch is pushed, the issue logic queries the filter with its address. A hit means the line is probably already in flight, so the candidate is dropped. The same query port serves demand misses. A demand miss that hits is counted by the surrounding logic as a late, partially covered prefetch.

The record is a 2048-bit array used as a two-hash Bloom filter, keyed on the line address. The line address is the byte address with its six offset bits removed, for 64-byte lines. A line is written only when the prefetch queue has accepted that request. Single entries are never removed. The filter ages instead: it counts accepted inserts, and the insert that would take the count past 256 wipes the whole array and the counter in one cycle. A synchronous clear input does the same wipe on demand.

Top module: `pf_line_filter`

## Requirements
- R1: After reset the array is empty and the insert count is zero, so every query returns miss and `qry_hit_o` is 0.
- R2: The key is the byte address shifted right by 6. Two byte addresses that differ only in bits [5:0] give the same query result.
- R3: `qry_hit_o` is registered. It shows the result of the query presented in the previous cycle, and it is 0 in any cycle after one in which `qry_vld_i` was low.
- R4: The line address is folded into two 11-bit indices. Index 0 is the XOR of the line's 11-bit slices, taken from bit 0 upward with the top slice zero-padded. Index 1 is the XOR of the same slices after slice s is rotated left by (1 + 3*s) mod 11. An insert sets both indexed bits. A query hits only when both of its indexed bits are set.
- R5: When `ins_vld_i` is low, nothing is written, whatever value `ins_addr_i` carries.
- R6: When a query and an insert occur in the same cycle, the query sees the array as it was before that insert.
- R7: Each accepted insert adds one to the count. An insert that arrives while the count is 256 clears the whole array and resets the count to 0, and its own line is not kept.
- R8: In a cycle where a wipe takes place, whether from the count limit or from `clr_i`, the query returns miss.
- R9: `clr_i` empties the array and zeroes the count. An insert presented in the same cycle is discarded.
- R10: After any wipe, counting starts again from zero. The next limit wipe comes on the 257th accepted insert after that wipe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, sampled synchronously |
| clr_i | input | 1 | Synchronous clear of array and insert count |
| qry_vld_i | input | 1 | Query strobe |
| qry_addr_i | input | ADDR_W | Byte address to look up |
| qry_hit_o | output | 1 | Registered lookup result for the previous cycle's query |
| ins_vld_i | input | 1 | Insert strobe (the prefetch queue accepted the request) |
| ins_addr_i | input | ADDR_W | Byte address of the accepted prefetch |

## Verification
The assertions check these rules on every cycle:
- The output stays low after an idle cycle or after a wipe.
- The array is empty after every wipe.
- Both hashed bits are set after each accepted insert.
- The array stays unchanged when there is no insert.
- The counter steps by one, or returns to zero on a limit or clear.

Some behaviour only the bench's scenarios can show: the hash folding, the offset bits being ignored, the order of a query and an insert in the same cycle, and the 257-insert ageing period seen at the ports. The bench covers these against a reference that keeps the set indices in a queue.

// File: rtl/pf_filt_pkg.sv
package pf_filt_pkg;

  // Destination bit of key bit 'bit_i' in an idx_w-wide fold.
  // Slice s = bit_i / idx_w is rotated left by (base + step*s).
  function automatic int unsigned fold_pos(input int unsigned bit_i,
                                           input int unsigned idx_w,
                                           input int unsigned base,
                                           input int unsigned step);
    return ((bit_i % idx_w) + base + step * (bit_i / idx_w)) % idx_w;
  endfunction

  // Rotation parameters of hash number h
  function automatic int unsigned hash_base(input int unsigned h);
    return h;
  endfunction

  function automatic int unsigned hash_step(input int unsigned h);
    return 3 * h;
  endfunction

endpackage

// File: rtl/pf_filt_hash.sv
module pf_filt_hash
  import pf_filt_pkg::*;
#(
  parameter int unsigned KEY_W    = 32,
  parameter int unsigned IDX_W    = 11,
  parameter int unsigned NUM_HASH = 2
) (
  input  logic [KEY_W-1:0]                key_i,
  output logic [NUM_HASH-1:0][IDX_W-1:0]  idx_o
);

  for (genvar h = 0; h < NUM_HASH; h++) begin : g_hash
    always_comb begin
      idx_o[h] = '0;
      for (int unsigned i = 0; i < KEY_W; i++) begin
        idx_o[h][fold_pos(i, IDX_W, hash_base(h), hash_step(h))] ^= key_i[i];
      end
    end
  end

endmodule

// File: rtl/pf_filt_bits.sv
module pf_filt_bits #(
  parameter int unsigned IDX_W    = 11,
  parameter int unsigned NUM_HASH = 2,
  localparam int unsigned DEPTH   = 1 << IDX_W
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            wipe_i,
  input  logic                            set_i,
  input  logic [NUM_HASH-1:0][IDX_W-1:0]  set_idx_i,
  input  logic [NUM_HASH-1:0][IDX_W-1:0]  rd_idx_i,
  output logic                            rd_all_o
);

  logic [DEPTH-1:0] bits_q;

  always_ff @(posedge clk) begin
    if (!rst_n || wipe_i) begin
      bits_q <= '0;
    end else if (set_i) begin
      for (int unsigned h = 0; h < NUM_HASH; h++) begin
        bits_q[set_idx_i[h]] <= 1'b1;
      end
    end
  end

  always_comb begin
    rd_all_o = 1'b1;
    for (int unsigned h = 0; h < NUM_HASH; h++) begin
      rd_all_o = rd_all_o & bits_q[rd_idx_i[h]];
    end
  end

  // R7 R9
  array_empty_after_wipe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wipe_i |=> ($countones(bits_q) == 0));

  // R4
  both_bits_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (set_i && !wipe_i) |=> (bits_q[$past(set_idx_i[0])] && bits_q[$past(set_idx_i[NUM_HASH-1])]));

  // R5
  array_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!set_i && !wipe_i) |=> $stable(bits_q));

endmodule

// File: rtl/pf_filt_age.sv
module pf_filt_age #(
  parameter int unsigned LIMIT  = 256,
  localparam int unsigned CNT_W = $clog2(LIMIT + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr_i,
  input  logic ins_i,
  output logic wipe_o
);

  logic [CNT_W-1:0] cnt_q;
  logic             at_limit;

  assign at_limit = (cnt_q == CNT_W'(LIMIT));
  assign wipe_o   = clr_i || (ins_i && at_limit);

  always_ff @(posedge clk) begin
    if (!rst_n || wipe_o) begin
      cnt_q <= '0;
    end else if (ins_i) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  // R7 R10
  count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ins_i && !wipe_o) |=> (cnt_q == $past(cnt_q) + 1'b1));

  // R7
  limit_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ins_i && !clr_i && at_limit) |=> (cnt_q == '0));

  // R9
  clear_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr_i |=> (cnt_q == '0));

endmodule

// File: rtl/pf_line_filter.sv
module pf_line_filter #(
  parameter int unsigned ADDR_W   = 32,
  parameter int unsigned LINE_OFS = 6,
  parameter int unsigned IDX_W    = 11,
  parameter int unsigned NUM_HASH = 2,
  parameter int unsigned LIMIT    = 256
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr_i,
  input  logic              qry_vld_i,
  input  logic [ADDR_W-1:0] qry_addr_i,
  output logic              qry_hit_o,
  input  logic              ins_vld_i,
  input  logic [ADDR_W-1:0] ins_addr_i
);

  logic [ADDR_W-1:0]               qry_key, ins_key;
  logic [NUM_HASH-1:0][IDX_W-1:0]  qry_idx, ins_idx;
  logic                            wipe_now;
  logic                            set_now;
  logic                            rd_all;

  assign qry_key = qry_addr_i >> LINE_OFS;
  assign ins_key = ins_addr_i >> LINE_OFS;

  pf_filt_hash #(.KEY_W(ADDR_W), .IDX_W(IDX_W), .NUM_HASH(NUM_HASH)) u_qhash (
    .key_i(qry_key), .idx_o(qry_idx));

  pf_filt_hash #(.KEY_W(ADDR_W), .IDX_W(IDX_W), .NUM_HASH(NUM_HASH)) u_ihash (
    .key_i(ins_key), .idx_o(ins_idx));

  pf_filt_age #(.LIMIT(LIMIT)) u_age (
    .clk(clk), .rst_n(rst_n), .clr_i(clr_i), .ins_i(ins_vld_i), .wipe_o(wipe_now));

  assign set_now = ins_vld_i && !wipe_now;

  pf_filt_bits #(.IDX_W(IDX_W), .NUM_HASH(NUM_HASH)) u_bits (
    .clk(clk), .rst_n(rst_n), .wipe_i(wipe_now), .set_i(set_now),
    .set_idx_i(ins_idx), .rd_idx_i(qry_idx), .rd_all_o(rd_all));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      qry_hit_o <= 1'b0;
    end else begin
      qry_hit_o <= qry_vld_i && !wipe_now && rd_all;
    end
  end

  // R3
  idle_no_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !qry_vld_i |=> !qry_hit_o);

  // R8
  wipe_miss_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wipe_now |=> !qry_hit_o);

  // R9
  clear_blocks_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr_i |-> !set_now);

endmodule

// File: tb/pf_line_filter_tb.sv
`timescale 1ns/1ps
module pf_line_filter_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        clr_i = 1'b0;
  logic        qry_vld_i = 1'b0;
  logic [31:0] qry_addr_i = '0;
  logic        qry_hit_o;
  logic        ins_vld_i = 1'b0;
  logic [31:0] ins_addr_i = '0;

  int n_chk = 0;
  int n_err = 0;
  string cur_req = "R1";

  // reference state: set indices in a queue, line count since last wipe
  int ref_idx[$];
  int ref_cnt = 0;
  bit ref_hit = 1'b0;

  always #2 clk = ~clk;

  pf_line_filter u_dut (
    .clk(clk), .rst_n(rst_n), .clr_i(clr_i),
    .qry_vld_i(qry_vld_i), .qry_addr_i(qry_addr_i), .qry_hit_o(qry_hit_o),
    .ins_vld_i(ins_vld_i), .ins_addr_i(ins_addr_i));

  function automatic int bh(input logic [31:0] byte_addr, input int k);
    logic [31:0] line;
    int acc;
    line = byte_addr >> 6;
    acc = 0;
    for (int s = 0; s * 11 < 32; s++) begin
      int ch;
      int r;
      ch = int'((line >> (s * 11)) & 32'h7FF);
      r  = (k == 0) ? 0 : (1 + 3 * s) % 11;
      ch = ((ch << r) | (ch >> (11 - r))) & 'h7FF;
      acc = acc ^ ch;
    end
    return acc;
  endfunction

  function automatic bit in_ref(input int idx);
    foreach (ref_idx[j]) if (ref_idx[j] == idx) return 1'b1;
    return 1'b0;
  endfunction

  task automatic chk(input string req, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: qry_hit_o=%0b expected=%0b at %0t", req, act, exp, $time);
    end
  endtask

  // One cycle: drive at negedge, model at posedge, compare at next negedge.
  task automatic cyc(input bit qv, input logic [31:0] qa,
                     input bit iv, input logic [31:0] ia, input bit cl);
    bit wipe;
    qry_vld_i = qv; qry_addr_i = qa;
    ins_vld_i = iv; ins_addr_i = ia; clr_i = cl;
    @(posedge clk);
    wipe = cl || (iv && ref_cnt == 256);
    ref_hit = qv && !wipe && in_ref(bh(qa, 0)) && in_ref(bh(qa, 1));
    if (wipe) begin
      ref_idx.delete();
      ref_cnt = 0;
    end else if (iv) begin
      ref_idx.push_back(bh(ia, 0));
      ref_idx.push_back(bh(ia, 1));
      ref_cnt++;
    end
    @(negedge clk);
    chk(cur_req, qry_hit_o, ref_hit);
  endtask

  task automatic idle();
    cyc(1'b0, '0, 1'b0, '0, 1'b0);
  endtask

  logic [31:0] first_a;
  logic [31:0] lfsr = 32'h1234_5678;

  function automatic logic [31:0] nxt(input logic [31:0] v);
    return {v[30:0], v[31] ^ v[21] ^ v[1] ^ v[0]};
  endfunction

  initial begin
    #(200000 * 4);
    n_err++;
    n_chk++;
    $display("FAIL watchdog: run did not finish (act=hung exp=done)");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1: empty after reset
    cur_req = "R1";
    chk("R1", qry_hit_o, 1'b0);
    cyc(1'b1, 32'h0000_1000, 1'b0, '0, 1'b0);
    chk("R1", qry_hit_o, 1'b0);

    // R4: insert then query hits
    cur_req = "R4";
    cyc(1'b0, '0, 1'b1, 32'h0001_2340, 1'b0);
    cyc(1'b1, 32'h0001_2340, 1'b0, '0, 1'b0);
    chk("R4", qry_hit_o, 1'b1);

    // R2: offset bits ignored
    cur_req = "R2";
    cyc(1'b1, 32'h0001_237F, 1'b0, '0, 1'b0);
    chk("R2", qry_hit_o, 1'b1);
    cyc(1'b1, 32'h0001_2380, 1'b0, '0, 1'b0);

    // R3: no query strobe -> no hit
    cur_req = "R3";
    cyc(1'b0, 32'h0001_2340, 1'b0, '0, 1'b0);
    chk("R3", qry_hit_o, 1'b0);

    // R5: insert strobe low writes nothing
    cur_req = "R5";
    cyc(1'b0, '0, 1'b0, 32'h0ABC_0000, 1'b0);
    cyc(1'b1, 32'h0ABC_0000, 1'b0, '0, 1'b0);
    chk("R5", qry_hit_o, 1'b0);

    // R6: same-cycle query and insert see the old array
    cur_req = "R6";
    cyc(1'b1, 32'h0055_5540, 1'b1, 32'h0055_5540, 1'b0);
    chk("R6", qry_hit_o, 1'b0);
    cyc(1'b1, 32'h0055_5540, 1'b0, '0, 1'b0);
    chk("R6", qry_hit_o, 1'b1);

    // R9: clear wipes, drops a simultaneous insert, query misses
    cur_req = "R9";
    cyc(1'b1, 32'h0055_5540, 1'b1, 32'h0077_0000, 1'b1);
    chk("R9", qry_hit_o, 1'b0);
    cyc(1'b1, 32'h0055_5540, 1'b0, '0, 1'b0);
    chk("R9", qry_hit_o, 1'b0);
    cyc(1'b1, 32'h0077_0000, 1'b0, '0, 1'b0);
    chk("R9", qry_hit_o, 1'b0);

    // R7 R8 R10: two full ageing periods
    for (int round = 0; round < 2; round++) begin
      cur_req = (round == 0) ? "R7" : "R10";
      first_a = lfsr << 6;
      for (int n = 0; n < 256; n++) begin
        lfsr = nxt(lfsr);
        cyc(1'b0, '0, 1'b1, (n == 0) ? first_a : lfsr, 1'b0);
      end
      cyc(1'b1, first_a, 1'b0, '0, 1'b0);
      chk(cur_req, qry_hit_o, 1'b1);
      lfsr = nxt(lfsr);
      cur_req = "R8";
      cyc(1'b1, first_a, 1'b1, lfsr, 1'b0);
      chk("R8", qry_hit_o, 1'b0);
      cur_req = "R7";
      cyc(1'b1, first_a, 1'b0, '0, 1'b0);
      chk("R7", qry_hit_o, 1'b0);
      cyc(1'b1, lfsr, 1'b0, '0, 1'b0);
      chk("R7", qry_hit_o, 1'b0);
    end

    // R4: mixed traffic over a small line pool, compared every cycle
    cur_req = "R4";
    for (int n = 0; n < 3000; n++) begin
      logic [31:0] qa;
      logic [31:0] ia;
      lfsr = nxt(lfsr);
      qa = {22'h0, lfsr[9:0]} << 3;
      ia = {22'h0, lfsr[25:16]} << 3;
      cyc(lfsr[28], qa, lfsr[30], ia, (lfsr[31:27] == 5'h1F));
    end

    idle();
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

endmodule